// File: doc/BRIEF.md
# T1 Frame Alignment Hunter with Multiple-Candidate Flag

This block takes a received DS1 bit stream one bit at a time and finds where the framing bit sits in the 193-bit frame. A frame is one framing bit followed by 24 eight-bit channels. The block runs in one of two modes, chosen by `esf_mode`: the 12-frame superframe (D3/D4) or the 24-frame extended superframe (ESF). While it hunts, it keeps a separate history of framing-position samples for each of the 193 bit positions. At the end of each 193-bit pass it checks how many positions carried a complete, correctly phased pattern.

The block locks only when exactly one position matches. If two or more positions match in the same pass, it raises `mimic` and keeps hunting. `mimic` then stays set until the next hunt starts, so it is still visible after lock. Once locked, the block checks each terminal-framing bit and pulses `ft_err` on every mismatch. A host can combine `mimic`, `ft_err` and its own CRC error count to decide whether to pulse `force_reframe`. The block also drops lock by itself when terminal-framing errors become dense.

The input is a valid/ready stream. `in_ready` is held high at all times, so the block never applies back-pressure. A bit is consumed on every clock edge where `in_valid` is high, and cycles with `in_valid` low have no effect on alignment state. `esf_mode` must be held constant and may only change together with a `force_reframe` pulse.

Top module: `t1_frame_sync`

## Requirements
- R1: `in_ready` is always 1. Only cycles with `in_valid` high advance the 193-position counter. Idle cycles interleaved in the stream do not change when lock is reached.
- R2: After reset the block is hunting, with `in_sync`, `mimic` and `ft_err` all 0.
- R3: In D3/D4 mode, the expected framing-bit sequence over superframe frames 1 to 12 is 1,0,0,0,1,1,0,1,1,1,0,0. Odd frames carry terminal framing and even frames carry signalling framing. From reset, a clean stream with zero data bits raises `in_sync` right after the 12×193-th accepted bit, and not before it.
- R4: In ESF mode, only frames 4, 8, 12, 16, 20 and 24 carry checked framing bits, with values 0,0,1,0,1,1. A clean ESF stream whose framing bit is at any fixed offset locks at the end of the 24th full pass, and not before.
- R5: If two or more positions match a full pattern cycle in the same pass, `mimic` becomes 1 after that pass's last bit and `in_sync` stays 0.
- R6: `mimic` holds through later passes and through a subsequent lock. It clears only when a new hunt starts, either from `force_reframe` or from loss of lock.
- R7: While locked, a terminal-framing bit that differs from its expected value raises `ft_err` for exactly one cycle after that bit is accepted. In ESF mode the terminal-framing bits are the six checked framing bits. A wrong D3/D4 signalling-framing bit raises no `ft_err` and does not affect lock.
- R8: While locked, once 2 of the last 4 terminal-framing bits are in error, `in_sync` drops on the same edge that raises the second error's `ft_err`. A single error among 4 keeps lock.
- R9: `force_reframe` clears `in_sync` and `mimic` on the next edge and restarts the hunt. After that, a clean stream relocks within 13 frames in D3/D4 mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| esf_mode | input | 1 | 1 selects ESF, 0 selects D3/D4 |
| force_reframe | input | 1 | One-cycle pulse that restarts the hunt |
| in_valid | input | 1 | Line bit present on `in_bit` |
| in_bit | input | 1 | Received line bit |
| in_ready | output | 1 | Always 1; the block never stalls the stream |
| in_sync | output | 1 | Frame alignment locked |
| mimic | output | 1 | More than one candidate matched during the hunt |
| ft_err | output | 1 | One-cycle pulse on a terminal-framing mismatch while locked |

## Verification
The per-position history, the pass counter and the phase register are internal state that the ports do not show directly. Their faults appear as timing faults on `in_sync`. A history that is short or stale moves lock earlier or later than the exact pass boundary. A wrong stored phase makes the first terminal-framing check after lock fail, so `ft_err` pulses and `in_sync` drops within two to four frames. A miscounted error window shows as lock that either survives two errors or drops on one. A `mimic` that clears too early or too late is caught at the lock that follows the second candidate and again at `force_reframe`.

// File: rtl/t1fs_pkg.sv
package t1fs_pkg;
  localparam int HIST_W = 24;
  localparam int PH_W   = $clog2(HIST_W);

  // superframe length in frames for the selected mode
  function automatic int sf_len(input logic esf);
    return esf ? 24 : 12;
  endfunction

  // frame index (0-based) carries a bit that takes part in matching
  function automatic logic is_chk(input logic esf, input int idx);
    return esf ? ((idx % 4) == 3) : 1'b1;
  endfunction

  // frame index carries a terminal-framing bit
  function automatic logic is_term(input logic esf, input int idx);
    return esf ? ((idx % 4) == 3) : ((idx % 2) == 0);
  endfunction

  function automatic logic exp_fbit(input logic esf, input int idx);
    logic [11:0] sf12;
    logic [5:0]  sf24;
    sf12 = 12'b001110110001;
    sf24 = 6'b110100;
    if (esf) return sf24[(idx / 4) % 6];
    return sf12[idx % 12];
  endfunction
endpackage

// File: rtl/t1fs_hist_mem.sv
module t1fs_hist_mem #(
  parameter int DEPTH = 193,
  parameter int W     = 24,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  assign rdata = mem[addr];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end
endmodule

// File: rtl/t1fs_phase_det.sv
module t1fs_phase_det
  import t1fs_pkg::*;
(
  input  logic              esf,
  input  logic [HIST_W-1:0] hist,   // bit 0 newest sample
  output logic              hit,
  output logic [PH_W-1:0]   phase   // frame index of the newest sample
);
  always_comb begin : p_det
    logic ok;
    int   len;
    int   idx;
    hit   = 1'b0;
    phase = '0;
    len   = sf_len(esf);
    for (int f = 0; f < HIST_W; f++) begin
      ok = (f < len);
      for (int i = 0; i < HIST_W; i++) begin
        idx = (f - i + 2 * HIST_W) % len;
        if (ok && i < len && is_chk(esf, idx) && hist[i] != exp_fbit(esf, idx))
          ok = 1'b0;
      end
      if (ok && !hit) begin
        hit   = 1'b1;
        phase = PH_W'(f);
      end
    end
  end
endmodule

// File: rtl/t1fs_sync_ctrl.sv
module t1fs_sync_ctrl
  import t1fs_pkg::*;
#(
  parameter int FRAME_BITS = 193,
  localparam int PW = $clog2(FRAME_BITS),
  localparam logic [PW-1:0] LAST = PW'(FRAME_BITS - 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            esf,
  input  logic            force_reframe,
  input  logic            accept,
  input  logic            bit_in,
  input  logic            hit,
  input  logic [PH_W-1:0] phase,
  output logic [PW-1:0]   pos,
  output logic            in_sync,
  output logic            mimic,
  output logic            ft_err
);
  logic [4:0]      pass_cnt;
  logic [1:0]      mcnt;
  logic [PW-1:0]   win_pos, lock_pos;
  logic [PH_W-1:0] win_ph, fidx;
  logic [3:0]      err_hist;

  logic            eval_en, at_last, fpos, term, bad, lose_now;
  logic [1:0]      tot;
  logic [3:0]      err_next;
  logic [PH_W-1:0] lock_ph;

  function automatic logic [PH_W-1:0] nxt(input logic [PH_W-1:0] p, input logic e);
    return (int'(p) == sf_len(e) - 1) ? '0 : p + 1'b1;
  endfunction

  assign eval_en  = int'(pass_cnt) >= sf_len(esf) - 1;
  assign at_last  = accept && (pos == LAST);
  assign tot      = (mcnt == 2'd2 || (mcnt == 2'd1 && hit)) ? 2'd2 : mcnt + {1'b0, hit};
  assign lock_ph  = (mcnt == 2'd0) ? phase : win_ph;
  assign fpos     = in_sync && accept && (pos == lock_pos);
  assign term     = is_term(esf, int'(fidx));
  assign bad      = fpos && term && (bit_in != exp_fbit(esf, int'(fidx)));
  assign err_next = {err_hist[2:0], bad};
  assign lose_now = fpos && term && ($countones(err_next) >= 2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos <= '0; pass_cnt <= '0; mcnt <= '0; win_pos <= '0; win_ph <= '0;
      lock_pos <= '0; fidx <= '0; err_hist <= '0;
      in_sync <= 1'b0; mimic <= 1'b0; ft_err <= 1'b0;
    end else begin
      ft_err <= 1'b0;
      if (accept) pos <= (pos == LAST) ? '0 : pos + 1'b1;
      if (force_reframe) begin
        in_sync <= 1'b0; mimic <= 1'b0; pass_cnt <= '0; mcnt <= '0;
      end else if (!in_sync) begin
        if (accept && eval_en && hit && mcnt == 2'd0) begin
          win_pos <= pos;
          win_ph  <= phase;
        end
        if (accept && eval_en) mcnt <= tot;
        if (at_last) begin
          mcnt <= '0;
          if (pass_cnt != 5'd31) pass_cnt <= pass_cnt + 1'b1;
          if (eval_en && tot == 2'd1) begin
            in_sync  <= 1'b1;
            lock_pos <= (mcnt == 2'd0) ? pos : win_pos;
            fidx     <= nxt(lock_ph, esf);
            err_hist <= '0;
          end
          if (eval_en && tot == 2'd2) mimic <= 1'b1;
        end
      end else if (fpos) begin
        fidx <= nxt(fidx, esf);
        if (term) begin
          ft_err   <= bad;
          err_hist <= err_next;
        end
        if (lose_now) begin
          in_sync <= 1'b0; mimic <= 1'b0; pass_cnt <= '0; mcnt <= '0;
        end
      end
    end
  end

  a_r1_idle_pos: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(pos));
  a_r3_lock_at_pass_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_sync) |-> $past(pos) == LAST);
  a_r5_mimic_blocks_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_sync && at_last && eval_en && tot == 2'd2 && !force_reframe) |=> (mimic && !in_sync));
  a_r6_mimic_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mimic && !force_reframe && !lose_now) |=> mimic);
  a_r7_err_only_locked: assert property (@(posedge clk) disable iff (!rst_n)
    ft_err |-> $past(in_sync));
  a_r8_drop_on_second: assert property (@(posedge clk) disable iff (!rst_n)
    lose_now |=> (!in_sync && ft_err));
  a_r9_reframe: assert property (@(posedge clk) disable iff (!rst_n)
    force_reframe |=> (!in_sync && !mimic));
endmodule

// File: rtl/t1_frame_sync.sv
module t1_frame_sync
  import t1fs_pkg::*;
#(
  parameter int FRAME_BITS = 193
) (
  input  logic clk,
  input  logic rst_n,
  input  logic esf_mode,
  input  logic force_reframe,
  input  logic in_valid,
  input  logic in_bit,
  output logic in_ready,
  output logic in_sync,
  output logic mimic,
  output logic ft_err
);
  localparam int PW = $clog2(FRAME_BITS);

  logic [PW-1:0]     pos;
  logic [HIST_W-1:0] h_old, h_new;
  logic              hit;
  logic [PH_W-1:0]   phase;

  assign in_ready = 1'b1;
  assign h_new    = {h_old[HIST_W-2:0], in_bit};

  t1fs_hist_mem #(.DEPTH(FRAME_BITS), .W(HIST_W)) u_mem (
    .clk(clk), .we(in_valid && !in_sync), .addr(pos),
    .wdata(h_new), .rdata(h_old)
  );

  t1fs_phase_det u_det (
    .esf(esf_mode), .hist(h_new), .hit(hit), .phase(phase)
  );

  t1fs_sync_ctrl #(.FRAME_BITS(FRAME_BITS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .esf(esf_mode), .force_reframe(force_reframe),
    .accept(in_valid), .bit_in(in_bit), .hit(hit), .phase(phase),
    .pos(pos), .in_sync(in_sync), .mimic(mimic), .ft_err(ft_err)
  );
endmodule

// File: tb/sim_t1_frame_sync.sv
module sim_t1_frame_sync;
  logic clk = 1'b0;
  logic rst_n, esf_mode, force_reframe, in_valid, in_bit;
  logic in_ready, in_sync, mimic, ft_err;
  int   n_chk = 0, n_bad = 0;
  int   frm = 0, bidx = 0;
  logic fe_f, sy_f;

  always #10 clk = ~clk;

  t1_frame_sync u0 (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic ref_f(input logic esf, input int idx);
    int d4[12] = '{1,0,0,0,1,1,0,1,1,1,0,0};
    int e6[6]  = '{0,0,1,0,1,1};
    if (esf) return ((idx % 4) == 3) ? logic'(e6[idx / 4]) : 1'b0;
    return logic'(d4[idx]);
  endfunction

  task automatic do_reset(input logic esf);
    esf_mode = esf; rst_n = 1'b0; in_valid = 1'b0; in_bit = 1'b0; force_reframe = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; frm = 0; bidx = 0;
    @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    in_valid = 1'b1; in_bit = b;
    @(negedge clk);
  endtask

  task automatic send_idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_gen(input logic flip, input logic cpy, input logic cinv);
    logic fv, b;
    fv = ref_f(esf_mode, frm % (esf_mode ? 24 : 12));
    b  = 1'b0;
    if (bidx == 0) b = fv ^ flip;
    else if (cpy && bidx == 100) b = fv ^ cinv;
    send_bit(b);
    if (bidx == 0) begin fe_f = ft_err; sy_f = in_sync; end
    bidx++;
    if (bidx == 193) begin bidx = 0; frm++; end
  endtask

  task automatic send_frame(input logic flip, input logic cpy, input logic cinv);
    repeat (193) send_gen(flip, cpy, cinv);
  endtask

  task automatic t_reset;
    do_reset(1'b0);
    chk("R2 in_sync", in_sync, 1'b0);
    chk("R2 mimic", mimic, 1'b0);
    chk("R2 ft_err", ft_err, 1'b0);
  endtask

  task automatic t_d4_lock;
    do_reset(1'b0);
    for (int k = 0; k < 11; k++) begin
      send_frame(1'b0, 1'b0, 1'b0);
      if (k < 3) send_idle(5);
    end
    chk("R1 in_ready", in_ready, 1'b1);
    repeat (192) send_gen(1'b0, 1'b0, 1'b0);
    chk("R3 R1 no lock before 12 frames", in_sync, 1'b0);
    send_gen(1'b0, 1'b0, 1'b0);
    chk("R3 lock at 12 frames", in_sync, 1'b1);
  endtask

  task automatic t_d4_errors;
    send_frame(1'b1, 1'b0, 1'b0);               // frame index 0: terminal bit wrong
    chk("R7 ft_err pulse", fe_f, 1'b1);
    chk("R8 single error keeps lock", sy_f, 1'b1);
    chk("R7 ft_err one cycle", ft_err, 1'b0);
    repeat (8) send_frame(1'b0, 1'b0, 1'b0);    // indices 1..8
    send_frame(1'b1, 1'b0, 1'b0);               // index 9: signalling bit wrong
    chk("R7 Fs error ignored", fe_f, 1'b0);
    chk("R7 Fs error keeps lock", sy_f, 1'b1);
    send_frame(1'b1, 1'b0, 1'b0);               // index 10: terminal wrong
    chk("R8 first error keeps lock", sy_f, 1'b1);
    send_frame(1'b0, 1'b0, 1'b0);               // index 11
    send_frame(1'b1, 1'b0, 1'b0);               // index 0: terminal wrong again
    chk("R8 second error flagged", fe_f, 1'b1);
    chk("R8 lock lost on 2 of 4", sy_f, 1'b0);
    chk("R6 mimic clear after loss", mimic, 1'b0);
  endtask

  task automatic t_esf;
    do_reset(1'b1);
    repeat (57) send_bit(1'b0);
    repeat (23) send_frame(1'b0, 1'b0, 1'b0);
    repeat (135) send_gen(1'b0, 1'b0, 1'b0);
    chk("R4 no lock before 24 passes", in_sync, 1'b0);
    send_gen(1'b0, 1'b0, 1'b0);
    chk("R4 lock at 24 passes", in_sync, 1'b1);
    while (bidx != 0) send_gen(1'b0, 1'b0, 1'b0);
    repeat (3) send_frame(1'b0, 1'b0, 1'b0);
    send_frame(1'b1, 1'b0, 1'b0);               // index 3: first pattern bit wrong
    chk("R7 ESF ft_err", fe_f, 1'b1);
    chk("R8 ESF single error keeps lock", in_sync, 1'b1);
  endtask

  task automatic t_mimic;
    do_reset(1'b0);
    repeat (11) send_frame(1'b0, 1'b1, 1'b0);
    repeat (192) send_gen(1'b0, 1'b1, 1'b0);
    chk("R5 mimic not before pass end", mimic, 1'b0);
    send_gen(1'b0, 1'b1, 1'b0);
    chk("R5 mimic set", mimic, 1'b1);
    chk("R5 no lock with two candidates", in_sync, 1'b0);
    send_frame(1'b0, 1'b1, 1'b1);               // copy broken
    chk("R6 lock after copy broken", in_sync, 1'b1);
    chk("R6 mimic held after lock", mimic, 1'b1);
    in_valid = 1'b0; force_reframe = 1'b1;
    @(negedge clk);
    force_reframe = 1'b0;
    chk("R9 reframe drops sync", in_sync, 1'b0);
    chk("R9 reframe clears mimic", mimic, 1'b0);
    repeat (13) send_frame(1'b0, 1'b0, 1'b0);
    chk("R9 relock after reframe", in_sync, 1'b1);
    chk("R9 mimic stays clear", mimic, 1'b0);
  endtask

  initial begin
    t_reset();
    t_d4_lock();
    t_d4_errors();
    t_esf();
    t_mimic();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule